// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Queue

This block turns an asynchronous serial line into parallel characters. A free-running 16x sample enable paces it. It finds a falling edge on the line and rechecks it half a bit later. It then samples each data bit at its centre, least significant bit first, and may also take a parity bit and a stop bit. Every finished character goes into a small receive queue. Three flags travel with each character: a parity error, a framing error and a break.

Software sets the character length (5 to 8 bits), the parity choice (none, even or odd) and whether the queue is in use. After reset the receiver holds at most one character, like a plain holding register. Once queue mode is enabled it buffers up to sixteen. A reader sees the oldest character and its flags, the fill level and a sticky overrun indication, and pops with a one-cycle read strobe.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty (`rdValid`=0, `fillLevel`=0), `overrun` is 0, and the block is in single-character mode.
- R2: `charLen` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Bits arrive least significant first. `rdData` holds them right-aligned, with the unused upper bits zero.
- R3: With `parityEn`=1, one parity bit follows the data. `parityOdd`=0 means even parity, 1 means odd. A mismatch sets `rdErr[0]` on that character only.
- R4: A start edge must still read low 8 sample enables after it is seen. If the line is high by then, the block returns to idle and stores nothing.
- R5: If the stop bit samples low, `rdErr[1]` (framing) is set. The data is still stored, and nothing new is accepted until the line goes high again.
- R6: If the start, data, parity and stop samples are all low, one entry is stored with data 0 and `rdErr`=3'b110 (break and framing). No further entry is stored until the line returns high.
- R7: In queue mode (`fifoEn`=1) up to 16 characters are held and read back in arrival order. `fillLevel` gives their number.
- R8: In single-character mode only one character is held. Any change of `fifoEn` empties the storage.
- R9: A character that completes while storage is full is dropped, and the stored entries are kept. `overrun` is then set and stays set until a `lsrRead` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | 16x oversampling enable |
| rxIn | input | 1 | Serial line, idle high |
| charLen | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parityEn | input | 1 | Expect a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| fifoEn | input | 1 | 1 = 16-entry queue, 0 = single holding entry |
| rdEn | input | 1 | Pop the oldest entry |
| lsrRead | input | 1 | Line-status read, clears overrun |
| rdData | output | 8 | Oldest character |
| rdErr | output | 3 | Flags of oldest: [0] parity, [1] framing, [2] break |
| rdValid | output | 1 | At least one entry stored |
| fillLevel | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: a 16-entry queue and 16x oversampling. The sample enable runs every other clock, so one bit lasts 32 clocks. With the full default depth, the bench can fill the queue to its limit, overflow it and drain it in order. A glitch shorter than half a bit reaches the mid-bit recheck, and a line held low for twelve bit times exercises the single break entry and the wait for the line to go high.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic startChar;
    logic takeData;
    logic takeParity;
    logic takeStop;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_HOLDLOW
  } rxState_t;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rxEntry_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxBit,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  output rxStrobe_t  strobe
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

  rxState_t state;
  logic [CW-1:0] cnt;
  logic [2:0] bitIdx;
  logic [2:0] lastBit;

  assign lastBit = 3'd4 + {1'b0, charLen};

  always_comb begin
    strobe = '0;
    if (sampleEn) begin
      case (state)
        S_START:  strobe.startChar  = (cnt == MID_LAST) && !rxBit;
        S_DATA:   strobe.takeData   = (cnt == BIT_LAST);
        S_PARITY: strobe.takeParity = (cnt == BIT_LAST);
        S_STOP:   strobe.takeStop   = (cnt == BIT_LAST);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (sampleEn) begin
      case (state)
        S_IDLE: if (!rxBit) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (cnt == MID_LAST) begin
          cnt    <= '0;
          bitIdx <= '0;
          state  <= rxBit ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == BIT_LAST) begin
          cnt <= '0;
          if (bitIdx == lastBit) state <= parityEn ? S_PARITY : S_STOP;
          else bitIdx <= bitIdx + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_PARITY: if (cnt == BIT_LAST) begin
          cnt   <= '0;
          state <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == BIT_LAST) begin
          cnt   <= '0;
          state <= rxBit ? S_IDLE : S_HOLDLOW;
        end else cnt <= cnt + 1'b1;
        S_HOLDLOW: if (rxBit) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: at most one strobe per cycle toward the datapath
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R4: a start bit that reads high at mid-bit returns to idle
  p_false_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_START && sampleEn && cnt == MID_LAST && rxBit) |=> state == S_IDLE);

  // R6: after a low stop sample nothing restarts while the line stays low
  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLDLOW && !rxBit) |=> state == S_HOLDLOW);
endmodule

// File: rtl/srx_data.sv
module srx_data
  import srx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxIn,
  output logic                        rxBit,
  input  rxStrobe_t                   strobe,
  input  logic [1:0]                  charLen,
  input  logic                        parityEn,
  input  logic                        parityOdd,
  input  logic                        fifoEn,
  input  logic                        rdEn,
  input  logic                        lsrRead,
  output logic [DATA_W-1:0]           rdData,
  output logic [ERR_W-1:0]            rdErr,
  output logic                        rdValid,
  output logic [$clog2(DEPTH+1)-1:0]  fillLevel,
  output logic                        overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [1:0] syncQ;
  logic [DATA_W-1:0] shiftQ, dataVal;
  logic allLowQ, parErrQ, modeQ, overQ;
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] countQ, capacity;
  rxEntry_t mem [DEPTH];
  rxEntry_t entry;
  logic push, full, doPush, doPop, flush, expPar;

  assign rxBit   = syncQ[1];
  assign dataVal = shiftQ >> (2'd3 - charLen);
  assign expPar  = parityOdd ? ~^dataVal : ^dataVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      shiftQ  <= '0;
      allLowQ <= 1'b0;
      parErrQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      if (strobe.startChar) begin
        shiftQ  <= '0;
        allLowQ <= 1'b1;
        parErrQ <= 1'b0;
      end
      if (strobe.takeData) begin
        shiftQ  <= {rxBit, shiftQ[DATA_W-1:1]};
        allLowQ <= allLowQ & !rxBit;
      end
      if (strobe.takeParity) begin
        parErrQ <= (rxBit != expPar);
        allLowQ <= allLowQ & !rxBit;
      end
    end
  end

  // entry assembled at the stop-bit sample
  always_comb begin
    entry.data   = dataVal;
    entry.err[2] = allLowQ && !rxBit;
    entry.err[1] = !rxBit;
    entry.err[0] = parErrQ && parityEn && !(allLowQ && !rxBit);
  end

  assign push     = strobe.takeStop;
  assign flush    = (fifoEn != modeQ);
  assign capacity = modeQ ? LW'(DEPTH) : LW'(1);
  assign full     = (countQ >= capacity);
  assign doPush   = push && !full && !flush;
  assign doPop    = rdEn && (countQ != '0) && !flush;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
      overQ  <= 1'b0;
    end else begin
      modeQ <= fifoEn;
      if (flush) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        countQ <= '0;
      end else begin
        if (doPush) wrPtr <= nextPtr(wrPtr);
        if (doPop)  rdPtr <= nextPtr(rdPtr);
        countQ <= countQ + LW'(doPush) - LW'(doPop);
      end
      if (push && full) overQ <= 1'b1;
      else if (lsrRead) overQ <= 1'b0;
    end
  end

  assign rdData    = mem[rdPtr].data;
  assign rdErr     = mem[rdPtr].err;
  assign rdValid   = (countQ != '0);
  assign fillLevel = countQ;
  assign overrun   = overQ;

  // R7: level never exceeds queue depth
  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= LW'(DEPTH));

  // R8: single-character mode never holds more than one entry
  p_bypass_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> countQ <= LW'(1));

  // R9: an arrival while full leaves the level untouched
  p_full_discard_r9: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !doPop && !flush) |=> countQ == $past(countQ));

  // R9: overrun raised by a dropped arrival
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |=> overQ);

  // R9: overrun stays until a status read
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overQ && !lsrRead) |=> overQ);

  // R6: a break entry carries all-zero data
  p_break_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && entry.err[2]) |-> entry.data == '0);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleEn,
  input  logic                        rxIn,
  input  logic [1:0]                  charLen,
  input  logic                        parityEn,
  input  logic                        parityOdd,
  input  logic                        fifoEn,
  input  logic                        rdEn,
  input  logic                        lsrRead,
  output logic [7:0]                  rdData,
  output logic [2:0]                  rdErr,
  output logic                        rdValid,
  output logic [$clog2(DEPTH+1)-1:0]  fillLevel,
  output logic                        overrun
);
  rxStrobe_t strobe;
  logic rxBit;

  srx_ctrl #(.OSR(OSR)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxBit(rxBit),
    .charLen(charLen), .parityEn(parityEn), .strobe(strobe)
  );

  srx_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .rxBit(rxBit), .strobe(strobe),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .fifoEn(fifoEn), .rdEn(rdEn), .lsrRead(lsrRead), .rdData(rdData),
    .rdErr(rdErr), .rdValid(rdValid), .fillLevel(fillLevel), .overrun(overrun)
  );
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int BITCLK = 32;

  logic clk = 0, rstN = 0, sampleEn = 0, rxIn = 1;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 0, parityOdd = 0, fifoEn = 0, rdEn = 0, lsrRead = 0;
  logic [7:0] rdData;
  logic [2:0] rdErr;
  logic rdValid, overrun;
  logic [4:0] fillLevel;
  int total = 0, bad = 0;

  serial_rx_queue dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxIn(rxIn), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .fifoEn(fifoEn), .rdEn(rdEn),
    .lsrRead(lsrRead), .rdData(rdData), .rdErr(rdErr), .rdValid(rdValid),
    .fillLevel(fillLevel), .overrun(overrun)
  );

  always #4 clk = ~clk;
  always @(negedge clk) sampleEn <= ~sampleEn;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int nbits);
    rxIn = lvl;
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int len, input bit corrupt,
                           input bit stopLvl);
    logic [7:0] m;
    m = d & 8'((1 << len) - 1);
    hold(1'b0, 1);
    for (int i = 0; i < len; i++) hold(d[i], 1);
    if (parityEn) hold((^m) ^ parityOdd ^ corrupt, 1);
    hold(stopLvl, 1);
    hold(1'b1, 2);
  endtask

  task automatic popCheck(input string req, input logic [7:0] expD, input logic [2:0] expE);
    chk({req, " data"}, rdData, expD);
    chk({req, " flags"}, rdErr, expE);
    rdEn = 1; @(negedge clk); rdEn = 0; @(negedge clk);
  endtask

  task automatic pulseLsr();
    lsrRead = 1; @(negedge clk); lsrRead = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", rdValid, 0);
    chk("R1 level", fillLevel, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_bypass();
    sendFrame(8'hA5, 8, 0, 1);
    chk("R1 holds one", fillLevel, 1);
    sendFrame(8'h3C, 8, 0, 1);
    chk("R8 single entry", fillLevel, 1);
    chk("R9 overrun set", overrun, 1);
    chk("R9 old kept", rdData, 8'hA5);
    repeat (5) @(negedge clk);
    chk("R9 sticky", overrun, 1);
    pulseLsr();
    chk("R9 cleared", overrun, 0);
    popCheck("R8 bypass", 8'hA5, 3'b000);
    chk("R8 empty", rdValid, 0);
  endtask

  task automatic t_lengths();
    fifoEn = 1; @(negedge clk); @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      charLen = 2'(l);
      sendFrame(8'hB7, 5 + l, 0, 1);
    end
    chk("R7 level 4", fillLevel, 4);
    popCheck("R2 len5", 8'h17, 3'b000);
    popCheck("R2 len6", 8'h37, 3'b000);
    popCheck("R2 len7", 8'h37, 3'b000);
    popCheck("R2 len8", 8'hB7, 3'b000);
    charLen = 2'd3;
  endtask

  task automatic t_parity();
    parityEn = 1; parityOdd = 0;
    sendFrame(8'h96, 8, 0, 1);
    sendFrame(8'h97, 8, 1, 1);
    parityOdd = 1;
    sendFrame(8'h96, 8, 0, 1);
    sendFrame(8'h13, 8, 1, 1);
    popCheck("R3 even ok", 8'h96, 3'b000);
    popCheck("R3 even bad", 8'h97, 3'b001);
    popCheck("R3 odd ok", 8'h96, 3'b000);
    popCheck("R3 odd bad", 8'h13, 3'b001);
    parityEn = 0; parityOdd = 0;
  endtask

  task automatic t_framing();
    sendFrame(8'h5A, 8, 0, 0);
    chk("R5 one entry", fillLevel, 1);
    popCheck("R5 framing", 8'h5A, 3'b010);
  endtask

  task automatic t_false_start();
    rxIn = 0; repeat (8) @(negedge clk);
    hold(1'b1, 20);
    chk("R4 nothing stored", fillLevel, 0);
    sendFrame(8'h81, 8, 0, 1);
    popCheck("R4 recovers", 8'h81, 3'b000);
  endtask

  task automatic t_break();
    hold(1'b0, 12);
    hold(1'b1, 2);
    chk("R6 single entry", fillLevel, 1);
    popCheck("R6 break", 8'h00, 3'b110);
    sendFrame(8'h42, 8, 0, 1);
    popCheck("R6 after break", 8'h42, 3'b000);
  endtask

  task automatic t_fill();
    int mism;
    for (int i = 0; i < 16; i++) sendFrame(8'(i * 7 + 1), 8, 0, 1);
    chk("R7 full level", fillLevel, 16);
    chk("R9 no overrun yet", overrun, 0);
    sendFrame(8'hEE, 8, 0, 1);
    chk("R9 level kept", fillLevel, 16);
    chk("R9 overrun on full", overrun, 1);
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      if (rdData !== 8'(i * 7 + 1) || rdErr !== 3'b000) mism++;
      rdEn = 1; @(negedge clk); rdEn = 0; @(negedge clk);
    end
    chk("R7 order mismatches", mism, 0);
    chk("R7 drained", rdValid, 0);
    pulseLsr();
  endtask

  task automatic t_modeswitch();
    sendFrame(8'h11, 8, 0, 1);
    chk("R8 stored before switch", fillLevel, 1);
    fifoEn = 0; @(negedge clk); @(negedge clk);
    chk("R8 switch flushes", fillLevel, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_lengths();
    t_parity();
    t_framing();
    t_false_start();
    t_break();
    t_fill();
    t_modeswitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule